// File: doc/BRIEF.md
# I2C Master Condition and Byte Controller

This block is the master side of an I2C link, driven by a small register port. A single write to the control register turns the mode bits into a bus condition. The bus-owner bit goes to 1 together with a command strobe at 0 to produce a START, or a repeated START when the link is already held. The same bit goes to 0 with the strobe at 0 to produce a STOP. The strobe bit is never stored and always reads back as 1. Any write with it high changes only the mode bits.

While the master holds the bus, a write to the data register shifts one byte out MSB first and then gives one acknowledge clock. The acknowledge-enable mode decides what a NACK does. With the mode at 0, a NACK is ignored and bytes may follow one another. With the mode at 1, a NACK stops further bytes until the next START.

A line monitor synchronises SCL and SDA and keeps a bus-busy flag from the START and STOP patterns it sees on the wires. Both lines are open drain, driven through active-high pull-down enables. SCL runs at a fixed division of the system clock: one SCL period is four quarters of `QTR_CLKS` clocks.

Top module: `i2c_cond_master`

Register map (2-bit address; read data is combinational):
- Address 0, control: bit0 command strobe (reads 1), bit1 bus owner/busy (reads the monitored busy flag), bit2 acknowledge enable, bit3 master mode, bit4 transmit mode.
- Address 1, data: a write starts a byte; a read returns the last byte written.
- Address 2, status: bit0 acknowledge flag, bit1 byte done.

## Requirements
- R1: After reset, the control register reads 8'h01, the status register reads 8'h00, and both pull-down enables are 0.
- R2: A control write with bit1=1 and bit0=0, made while master and transmit were both already 1, drives one START onto an idle bus. SDA falls while SCL is high, then SCL is held low and control bit1 reads 1.
- R3: The same START write made while the bus is held gives a repeated START: SDA falls again while SCL is high, busy stays 1, and the acknowledge flag clears.
- R4: A control write with bit1=0 and bit0=0, made while the bus is held, drives a STOP: SDA rises while SCL is high, both enables return to 0, and control bit1 reads 0.
- R5: A control write with bit0=1 issues no condition whatever bit1 holds, and bit0 of the control register always reads 1.
- R6: A START or STOP write is ignored unless master (bit3) and transmit (bit4) were both 1 before that write.
- R7: The busy flag sets on any SDA fall with SCL high and clears on any SDA rise with SCL high, including conditions made by another device.
- R8: A data write while the bus is held sends the 8 bits MSB first on SCL rising edges, releases SDA for a ninth clock, and then sets status bit1.
- R9: With acknowledge enable at 0, a NACK on the ninth clock leaves status bit0 at 0 and the next data write still transfers.
- R10: With acknowledge enable at 1, a NACK sets status bit0 to 1. Later data writes make no SCL clocks until a START is issued.
- R11: During a byte, SDA changes only while SCL is low.
- R12: A data write while the bus is not held by this master makes no SCL clocks and leaves status bit1 at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |

## Verification
The bench walks bytes with every combination of acknowledge enable and slave response. It checks that the NACK with the mode off neither sets the flag nor blocks the next byte. A design that tested the flag without the mode would stall there. After a suspending NACK it counts SCL rises across a further data write, which catches a controller that keeps clocking. It tries commands with the mode bits unset or with the strobe high, and a data write on an unowned bus; a gate that was too loose would show extra START events or clocks. A device outside the block drives START and STOP to prove the busy flag follows the wires rather than the commands.

// File: rtl/i2c_cond_pkg.sv
package i2c_cond_pkg;
   typedef enum logic [2:0] {
      E_IDLE,
      E_HOLD,
      E_START,
      E_STOP,
      E_BYTE
   } eng_state_t;

   localparam logic [1:0] A_CTRL = 2'd0;
   localparam logic [1:0] A_DATA = 2'd1;
   localparam logic [1:0] A_STAT = 2'd2;

   localparam int B_STROBE = 0;
   localparam int B_BUSY   = 1;
   localparam int B_ACKEN  = 2;
   localparam int B_MST    = 3;
   localparam int B_TX     = 4;

   localparam int B_ACKF   = 0;
   localparam int B_DONE   = 1;
endpackage

// File: rtl/i2c_line_monitor.sv
module i2c_line_monitor #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_in,
   input  logic sda_in,
   output logic sda_s,
   output logic start_det,
   output logic stop_det,
   output logic busy
);
   localparam int N_LINES = 2;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [N_LINES-1:0] raw;
   logic [N_LINES-1:0] synced;
   logic scl_p, sda_p;

   assign raw = {scl_in, sda_in};

   for (genvar g = 0; g < N_LINES; g++) begin : g_sync
      logic [SYNC_STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '1;
         else        chain <= {chain[SYNC_STAGES-2:0], raw[g]};
      end
      assign synced[g] = chain[SYNC_STAGES-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_p <= 1'b1;
         sda_p <= 1'b1;
      end else begin
         scl_p <= synced[1];
         sda_p <= synced[0];
      end
   end

   assign sda_s     = synced[0];
   assign start_det = synced[1] & scl_p & sda_p & ~synced[0];
   assign stop_det  = synced[1] & scl_p & ~sda_p & synced[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         busy <= 1'b0;
      else if (start_det) busy <= 1'b1;
      else if (stop_det)  busy <= 1'b0;
   end
endmodule

// File: rtl/i2c_quarter_timer.sv
module i2c_quarter_timer #(
   parameter int QTR_CLKS = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   localparam int CW = (QTR_CLKS > 1) ? $clog2(QTR_CLKS) : 1;
   localparam logic [CW-1:0] LAST = CW'(QTR_CLKS - 1);

   if (QTR_CLKS < 4) begin : g_bad_qtr
      $error("QTR_CLKS must be at least 4");
   end

   logic [CW-1:0] cnt;

   assign tick = run && (cnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (!run) cnt <= '0;
      else if (tick) cnt <= '0;
      else           cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/i2c_bit_engine.sv
module i2c_bit_engine
   import i2c_cond_pkg::*;
#(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              start_cmd,
   input  logic              stop_cmd,
   input  logic              data_go,
   input  logic [BYTE_W-1:0] tx_byte,
   input  logic              ack_en,
   input  logic              sda_s,
   output eng_state_t        state,
   output logic              run,
   output logic              scl_oe,
   output logic              sda_oe,
   output logic              ack_flag,
   output logic              done
);
   localparam int BW = $clog2(BYTE_W + 1);
   localparam logic [BW-1:0] ACK_BIT  = BW'(BYTE_W);
   localparam logic [BW-1:0] LAST_BIT = BW'(BYTE_W - 1);

   logic [1:0]        step;
   logic [BW-1:0]     bitn;
   logic [BYTE_W-1:0] shreg;

   assign run = (state == E_START) || (state == E_STOP) || (state == E_BYTE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= E_IDLE;
         step     <= '0;
         bitn     <= '0;
         shreg    <= '0;
         scl_oe   <= 1'b0;
         sda_oe   <= 1'b0;
         ack_flag <= 1'b0;
         done     <= 1'b0;
      end else begin
         unique case (state)
            E_IDLE, E_HOLD: begin
               if (start_cmd) begin
                  state    <= E_START;
                  step     <= '0;
                  sda_oe   <= 1'b0;
                  ack_flag <= 1'b0;
                  done     <= 1'b0;
               end else if (stop_cmd && state == E_HOLD) begin
                  state  <= E_STOP;
                  step   <= '0;
                  sda_oe <= 1'b1;
               end else if (data_go && state == E_HOLD && !ack_flag) begin
                  state  <= E_BYTE;
                  step   <= '0;
                  bitn   <= '0;
                  shreg  <= tx_byte;
                  sda_oe <= ~tx_byte[BYTE_W-1];
                  done   <= 1'b0;
               end
            end
            E_START: if (tick) begin
               step <= step + 2'd1;
               unique case (step)
                  2'd0: scl_oe <= 1'b0;
                  2'd1: sda_oe <= 1'b1;
                  2'd2: scl_oe <= 1'b1;
                  2'd3: state  <= E_HOLD;
               endcase
            end
            E_STOP: if (tick) begin
               step <= step + 2'd1;
               unique case (step)
                  2'd0: scl_oe <= 1'b0;
                  2'd1: sda_oe <= 1'b0;
                  2'd2: ;
                  2'd3: state  <= E_IDLE;
               endcase
            end
            E_BYTE: if (tick) begin
               step <= step + 2'd1;
               unique case (step)
                  2'd0: scl_oe <= 1'b0;
                  2'd1: ;
                  2'd2: begin
                     scl_oe <= 1'b1;
                     if (bitn == ACK_BIT && ack_en && sda_s) ack_flag <= 1'b1;
                  end
                  2'd3: begin
                     if (bitn == ACK_BIT) begin
                        state <= E_HOLD;
                        done  <= 1'b1;
                     end else begin
                        bitn   <= bitn + 1'b1;
                        shreg  <= shreg << 1;
                        sda_oe <= (bitn == LAST_BIT) ? 1'b0 : ~shreg[BYTE_W-2];
                     end
                  end
               endcase
            end
            default: state <= E_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/i2c_cond_master.sv
module i2c_cond_master
   import i2c_cond_pkg::*;
#(
   parameter int QTR_CLKS    = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [1:0] wr_addr,
   input  logic [7:0] wr_data,
   input  logic [1:0] rd_addr,
   output logic [7:0] rd_data,
   input  logic       scl_in,
   input  logic       sda_in,
   output logic       scl_oe,
   output logic       sda_oe
);
   logic       ack_en_q, mst_q, tx_q;
   logic [7:0] data_q;
   logic       cmd_ok, start_cmd, stop_cmd, data_go;
   logic       tick, run, sda_s, start_det, stop_det, busy;
   logic       ack_flag, done;
   eng_state_t eng_state;

   assign cmd_ok    = wr_en && (wr_addr == A_CTRL) && !wr_data[B_STROBE] && mst_q && tx_q;
   assign start_cmd = cmd_ok && wr_data[B_BUSY];
   assign stop_cmd  = cmd_ok && !wr_data[B_BUSY];
   assign data_go   = wr_en && (wr_addr == A_DATA);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack_en_q <= 1'b0;
         mst_q    <= 1'b0;
         tx_q     <= 1'b0;
         data_q   <= '0;
      end else if (wr_en) begin
         if (wr_addr == A_CTRL) begin
            ack_en_q <= wr_data[B_ACKEN];
            mst_q    <= wr_data[B_MST];
            tx_q     <= wr_data[B_TX];
         end
         if (wr_addr == A_DATA) data_q <= wr_data;
      end
   end

   always_comb begin
      rd_data = '0;
      unique case (rd_addr)
         A_CTRL: begin
            rd_data[B_STROBE] = 1'b1;
            rd_data[B_BUSY]   = busy;
            rd_data[B_ACKEN]  = ack_en_q;
            rd_data[B_MST]    = mst_q;
            rd_data[B_TX]     = tx_q;
         end
         A_DATA: rd_data = data_q;
         A_STAT: begin
            rd_data[B_ACKF] = ack_flag;
            rd_data[B_DONE] = done;
         end
         default: rd_data = '0;
      endcase
   end

   i2c_line_monitor #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
      .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
      .sda_s(sda_s), .start_det(start_det), .stop_det(stop_det), .busy(busy)
   );

   i2c_quarter_timer #(.QTR_CLKS(QTR_CLKS)) u_tmr (
      .clk(clk), .rst_n(rst_n), .run(run), .tick(tick)
   );

   i2c_bit_engine #(.BYTE_W(8)) u_eng (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .start_cmd(start_cmd), .stop_cmd(stop_cmd), .data_go(data_go),
      .tx_byte(wr_data), .ack_en(ack_en_q), .sda_s(sda_s),
      .state(eng_state), .run(run), .scl_oe(scl_oe), .sda_oe(sda_oe),
      .ack_flag(ack_flag), .done(done)
   );
endmodule

// File: rtl/i2c_cond_checker.sv
module i2c_cond_checker
   import i2c_cond_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input eng_state_t state,
   input logic       scl_oe,
   input logic       sda_oe,
   input logic       busy,
   input logic       start_det,
   input logic       stop_det,
   input logic       ack_flag,
   input logic       ack_en,
   input logic       mst,
   input logic       tx,
   input logic       wr_en,
   input logic [1:0] wr_addr,
   input logic [7:0] wr_data
);
   logic rest;
   assign rest = (state == E_IDLE) || (state == E_HOLD);

   p_idle_released_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (state == E_IDLE) |-> (!scl_oe && !sda_oe));

   p_busy_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start_det));

   p_busy_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(stop_det));

   p_mode_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == A_CTRL && !wr_data[B_STROBE] && !(mst && tx) && rest)
      |=> (state == $past(state)));

   p_strobe_noop_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == A_CTRL && wr_data[B_STROBE] && rest)
      |=> (state == $past(state)));

   p_sda_low_phase_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(sda_oe) && $past(state) == E_BYTE) |-> (scl_oe && $past(scl_oe)));

   p_ackflag_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ack_flag) |-> $past(ack_en));

   p_nack_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_flag && state == E_HOLD && wr_en && wr_addr == A_DATA) |=> (state == E_HOLD));
endmodule

bind i2c_cond_master i2c_cond_checker u_chk (
   .clk(clk), .rst_n(rst_n), .state(eng_state), .scl_oe(scl_oe), .sda_oe(sda_oe),
   .busy(busy), .start_det(start_det), .stop_det(stop_det), .ack_flag(ack_flag),
   .ack_en(ack_en_q), .mst(mst_q), .tx(tx_q),
   .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
);

// File: tb/sim_i2c_cond_master.sv
module sim_i2c_cond_master;
   localparam int TCLK = 10;
   localparam int QTR  = 4;
   localparam logic [1:0] AC = 2'd0, AD = 2'd1, AS = 2'd2;
   localparam int NV = 4;
   // {ack_en, slave_nack, data}
   localparam logic [9:0] VEC [NV] = '{
      {1'b0, 1'b1, 8'hA5},
      {1'b0, 1'b0, 8'h3C},
      {1'b1, 1'b0, 8'h81},
      {1'b1, 1'b1, 8'hFF}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0;
   logic [1:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [1:0] rd_addr = '0;
   logic [7:0] rd_data;
   logic scl_oe, sda_oe;
   logic slv_pull = 1'b0, ext_sda = 1'b0, nack_mode = 1'b0, in_byte = 1'b0;
   wire  scl_line = !scl_oe;
   wire  sda_line = !(sda_oe || slv_pull || ext_sda);

   int checks = 0, errors = 0;
   int starts = 0, stops = 0, rises = 0, glitches = 0, bitc = 0;
   logic [7:0] rxb = '0;

   always #(TCLK/2) clk = ~clk;

   i2c_cond_master #(.QTR_CLKS(QTR), .SYNC_STAGES(2)) u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .scl_in(scl_line), .sda_in(sda_line),
      .scl_oe(scl_oe), .sda_oe(sda_oe)
   );

   // bus observer and slave model
   always @(negedge sda_line) if (scl_line === 1'b1) begin starts++; bitc = 0; end
   always @(posedge sda_line) if (scl_line === 1'b1) stops++;
   always @(sda_line) if (scl_line === 1'b1 && in_byte) glitches++;
   always @(posedge scl_line) begin
      rises++;
      if (bitc < 8) rxb = {rxb[6:0], sda_line};
      bitc++;
   end
   always @(negedge scl_line) begin
      if (bitc == 8) slv_pull = !nack_mode;
      else if (bitc == 9) begin slv_pull = 1'b0; bitc = 0; end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk); rd_addr = a; #1; d = rd_data;
   endtask

   task automatic wait_done();
      logic [7:0] s;
      for (int i = 0; i < 400; i++) begin
         rd(AS, s);
         if (s[1]) break;
         repeat (4) @(negedge clk);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual timeout expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] r;
      int snap;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      starts = 0; stops = 0; rises = 0; glitches = 0; bitc = 0;
      repeat (4) @(negedge clk);

      // R1 reset state
      rd(AC, r); chk("R1 ctrl", r, 8'h01);
      rd(AS, r); chk("R1 stat", r, 8'h00);
      chk("R1 oe", {scl_oe, sda_oe}, 2'b00);

      // R12 data write on an unowned bus
      wr(AD, 8'hA5); repeat (50*QTR) @(negedge clk);
      chk("R12 rises", rises, 0);
      rd(AS, r); chk("R12 done", r[1], 1'b0);

      // R6 mode gate: no modes, then master without transmit
      wr(AC, 8'h02); repeat (8*QTR) @(negedge clk);
      wr(AC, 8'h09); wr(AC, 8'h0A); repeat (8*QTR) @(negedge clk);
      chk("R6 starts", starts, 0);
      rd(AC, r); chk("R6 busy", r[1], 1'b0);

      // R5 strobe high: modes set, no condition
      wr(AC, 8'h1B); repeat (8*QTR) @(negedge clk);
      chk("R5 starts", starts, 0);
      rd(AC, r); chk("R5 ctrl", r, 8'h19);

      // R2 START
      wr(AC, 8'h1A); repeat (6*QTR + 10) @(negedge clk);
      chk("R2 starts", starts, 1);
      rd(AC, r); chk("R2 busy", r[1], 1'b1);
      chk("R2 scl held", scl_oe, 1'b1);

      // R8 R9 R10 vector walk
      for (int v = 0; v < NV; v++) begin
         wr(AC, 8'h19 | {5'b0, VEC[v][9], 2'b00});
         nack_mode = VEC[v][8];
         in_byte = 1'b1;
         wr(AD, VEC[v][7:0]);
         wait_done();
         in_byte = 1'b0;
         chk("R8 byte", rxb, VEC[v][7:0]);
         rd(AS, r);
         chk("R8 done", r[1], 1'b1);
         chk("R9 R10 ackflag", r[0], VEC[v][9] & VEC[v][8]);
      end

      // R10 suspended after NACK
      snap = rises;
      wr(AD, 8'h55); repeat (50*QTR) @(negedge clk);
      chk("R10 no clocks", rises, snap);
      rd(AS, r); chk("R10 flag kept", r[0], 1'b1);

      // R11 SDA stable while SCL high during bytes
      chk("R11 glitches", glitches, 0);

      // R3 repeated START
      wr(AC, 8'h1A); repeat (6*QTR + 10) @(negedge clk);
      chk("R3 starts", starts, 2);
      rd(AC, r); chk("R3 busy", r[1], 1'b1);
      rd(AS, r); chk("R3 flag clear", r[0], 1'b0);

      // R4 STOP
      wr(AC, 8'h18); repeat (6*QTR + 10) @(negedge clk);
      chk("R4 stops", stops, 1);
      rd(AC, r); chk("R4 busy", r[1], 1'b0);
      chk("R4 oe", {scl_oe, sda_oe}, 2'b00);

      // R7 conditions from another device
      ext_sda = 1'b1; repeat (20) @(negedge clk);
      rd(AC, r); chk("R7 ext start", r[1], 1'b1);
      ext_sda = 1'b0; repeat (20) @(negedge clk);
      rd(AC, r); chk("R7 ext stop", r[1], 1'b0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule